// File: doc/BRIEF.md
# Receive Word FIFO with Programmable Level Flags

This block buffers 32-bit words arriving from a parallel cable receiver until a DMA engine drains them. A word is taken in only while the receive path is enabled. Words leave in arrival order through a registered read port. Both sides use the same clock.

A threshold register sets two levels: how low the fill may fall before the buffer counts as nearly drained, and how much headroom remains before it counts as nearly full. The status word reports the level conditions as active-high "not" flags. It also holds two sticky error bits. One records a word lost because the buffer was full. The other records a read made while the buffer was empty. Each error bit is cleared by writing a one to its own position. A flush control empties the buffer in one cycle. A word-count output gives the current fill, and a size output gives the capacity.

After a synchronous reset the buffer stays closed for a configurable number of cycles so that its contents can settle. During that time `ready_o` is low and the buffer takes no words and returns no words.

Top module: `rx_word_fifo`

## Requirements
- R1: A word is stored only on a cycle where `wr_en_i`, `rx_enable_i` and `ready_o` are all high, `flush_i` is low and the buffer is not full. Words are read out in the order they were stored. On an accepted read, `rd_data_o` shows the oldest word from the clock edge that takes the read.
- R2: The low 20 bits of `count_o` hold the number of stored words and the upper bits read zero. `size_o` reads the capacity, which is 2^ADDR_W.
- R3: Status bit 12 is high when at least one word is stored. Status bit 15 is high when fewer words than the capacity are stored. Status bits that are not named in these requirements read zero.
- R4: In the threshold register, bits 15:0 hold the nearly-drained level AE and bits 23:16 hold the headroom level AF. Bits 31:24 ignore writes and read zero. After reset, AE is AE_INIT and AF is AF_INIT.
- R5: Status bit 13 is high exactly when the fill count is greater than AE.
- R6: Status bit 14 is high exactly when the fill count plus AF is less than the capacity. This includes AF values that exceed the capacity, which force bit 14 low.
- R7: A write attempted while the buffer is full is dropped and sets status bit 23 (overrun). The stored words are left unchanged.
- R8: A read attempted while the buffer is empty leaves `rd_data_o` unchanged and sets status bit 22 (underrun).
- R9: Bits 22 and 23 hold once set. Each is cleared by a `stat_clr_i` cycle whose data has a one at that bit's position, and a zero at that position leaves the bit as it is. If a new error event and a clear arrive in the same cycle, the bit stays set.
- R10: `flush_i` empties the buffer on the next edge and overrides any read or write in the same cycle. It leaves `rd_data_o` and both error bits unchanged.
- R11: For SETTLE_CYC cycles after reset, `ready_o` stays low and reads and writes are ignored.
- R12: Synchronous reset sets the fill count to zero, clears both error bits, sets `rd_data_o` to zero and restores the threshold defaults.
- R13: A read and a write accepted in the same cycle on a buffer that is neither empty nor full both take effect, and the fill count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable_i | input | 1 | Receive enable; gates incoming writes |
| wr_en_i | input | 1 | Write request from the cable receiver |
| wr_data_i | input | 32 | Word to store |
| rd_en_i | input | 1 | Read request from the DMA engine |
| rd_data_o | output | 32 | Registered read data |
| flush_i | input | 1 | Empty the buffer |
| thr_we_i | input | 1 | Threshold register write strobe |
| thr_wdata_i | input | 32 | Threshold register write data |
| thr_o | output | 32 | Threshold register readback |
| stat_clr_i | input | 1 | Status write strobe (write-one-to-clear) |
| stat_clr_data_i | input | 32 | Status write data; ones at bits 22/23 clear those bits |
| status_o | output | 32 | Level flags and sticky error bits |
| count_o | output | 32 | Current fill count in bits 19:0 |
| size_o | output | 32 | Capacity in words |
| ready_o | output | 1 | Buffer open for access after the settle time |

## Verification
The assertions assume that every control input holds a known 0 or 1 at each clock edge and that reset is applied before the first checked edge. They also assume that `count_o` counts on the clock edges. Under those conditions the bound on the count and the overrun, underrun and flush consequences follow from the port values alone. The stimulus drives every input at the falling edge from one sequence and asserts reset for several cycles at time zero. It then mixes directed corner cases with a long random mix of reads, writes, flushes, clears and threshold writes. That mix deliberately includes writes while full, reads while empty, and clears that coincide with new error events.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int REG_W = 32;
  localparam int CNT_FIELD_W = 20;

  localparam int ST_NEMPTY  = 12;
  localparam int ST_NAEMPTY = 13;
  localparam int ST_NAFULL  = 14;
  localparam int ST_NFULL   = 15;
  localparam int ST_UNDER   = 22;
  localparam int ST_OVER    = 23;

  localparam int THR_W      = 24;
  localparam int THR_AE_LSB = 0;
  localparam int THR_AE_W   = 16;
  localparam int THR_AF_LSB = 16;
  localparam int THR_AF_W   = 8;

  typedef logic [REG_W-1:0] rxf_reg_t;
  typedef logic [THR_W-1:0] rxf_thr_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // write port: plain synchronous write, no reset, so block RAM fits
  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_addr] <= wr_data;
  end

  // read port: output register with synchronous reset, held when idle
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_go) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/rxf_track.sv
module rxf_track #(
  parameter int ADDR_W     = 5,
  parameter int SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic              flush,
  output logic              ready,
  output logic              wr_go,
  output logic              rd_go,
  output logic              ovf_evt,
  output logic              udf_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W:0]   cnt_q,
  output logic [ADDR_W:0]   cnt_d
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic ready_q;

  generate
    if (SETTLE_CYC > 0) begin : g_settle
      localparam int SW = $clog2(SETTLE_CYC + 1);
      logic [SW-1:0] settle_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          settle_q <= SW'(SETTLE_CYC);
          ready_q  <= 1'b0;
        end else if (settle_q != '0) begin
          settle_q <= settle_q - SW'(1);
          ready_q  <= (settle_q == SW'(1));
        end else begin
          ready_q  <= 1'b1;
        end
      end
    end else begin : g_nosettle
      assign ready_q = 1'b1;
    end
  endgenerate

  logic full_now, empty_now, wr_try, rd_try;

  assign full_now  = (cnt_q == FULL_CNT);
  assign empty_now = (cnt_q == '0);
  assign wr_try    = ready_q & wr_req & ~flush;
  assign rd_try    = ready_q & rd_req & ~flush;

  assign wr_go   = wr_try & ~full_now;
  assign rd_go   = rd_try & ~empty_now;
  assign ovf_evt = wr_try & full_now;
  assign udf_evt = rd_try & empty_now;
  assign ready   = ready_q;

  always_comb begin
    if (flush) cnt_d = '0;
    else       cnt_d = cnt_q + CNT_W'(wr_go) - CNT_W'(rd_go);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_addr <= '0;
      rd_addr <= '0;
    end else begin
      if (wr_go) wr_addr <= wr_addr + ADDR_W'(1);
      if (rd_go) rd_addr <= rd_addr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags
  import rxf_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int AE_INIT = 4,
  parameter int AF_INIT = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [ADDR_W:0] cnt_d,
  input  logic           thr_we,
  input  rxf_thr_t       thr_wdata,
  input  logic           clr_we,
  input  logic [1:0]     clr_bits,
  input  logic           ovf_evt,
  input  logic           udf_evt,
  output rxf_thr_t       thr_q,
  output rxf_reg_t       status_q
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CMP_W = THR_AE_W + 1;
  localparam rxf_thr_t THR_RST = {THR_AF_W'(AF_INIT), THR_AE_W'(AE_INIT)};

  rxf_thr_t          thr_d;
  logic [CMP_W-1:0]  cnt_x, ae_x, af_sum;
  logic              ovr_d, udr_d;
  rxf_reg_t          status_d;

  assign thr_d  = thr_we ? thr_wdata : thr_q;
  assign cnt_x  = CMP_W'(cnt_d);
  assign ae_x   = CMP_W'(thr_d[THR_AE_LSB +: THR_AE_W]);
  assign af_sum = cnt_x + CMP_W'(thr_d[THR_AF_LSB +: THR_AF_W]);

  // sticky errors: a new event wins over a clear in the same cycle
  assign ovr_d = (status_q[ST_OVER]  & ~(clr_we & clr_bits[1])) | ovf_evt;
  assign udr_d = (status_q[ST_UNDER] & ~(clr_we & clr_bits[0])) | udf_evt;

  always_comb begin
    status_d             = '0;
    status_d[ST_NEMPTY]  = (cnt_d != '0);
    status_d[ST_NAEMPTY] = (cnt_x > ae_x);
    status_d[ST_NAFULL]  = (af_sum < CMP_W'(DEPTH));
    status_d[ST_NFULL]   = (cnt_x != CMP_W'(DEPTH));
    status_d[ST_UNDER]   = udr_d;
    status_d[ST_OVER]    = ovr_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q    <= THR_RST;
      status_q <= '0;
      status_q[ST_NAFULL] <= (CMP_W'(AF_INIT) < CMP_W'(DEPTH));
      status_q[ST_NFULL]  <= 1'b1;
      status_q[ST_NAEMPTY] <= 1'b0;
    end else begin
      thr_q    <= thr_d;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
  import rxf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int SETTLE_CYC = 16,
  parameter int AE_INIT    = 4,
  parameter int AF_INIT    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_enable_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        rd_en_i,
  output logic [31:0] rd_data_o,
  input  logic        flush_i,
  input  logic        thr_we_i,
  input  logic [31:0] thr_wdata_i,
  output logic [31:0] thr_o,
  input  logic        stat_clr_i,
  input  logic [31:0] stat_clr_data_i,
  output logic [31:0] status_o,
  output logic [31:0] count_o,
  output logic [31:0] size_o,
  output logic        ready_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;

  logic              wr_go, rd_go, ovf_evt, udf_evt, ready;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rd_word;
  rxf_thr_t          thr_q;
  rxf_reg_t          status_q;

  wire unused_bits = ^{stat_clr_data_i[31:24], stat_clr_data_i[21:0],
                       thr_wdata_i[31:THR_W]};

  rxf_track #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) u_track (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_en_i & rx_enable_i),
    .rd_req  (rd_en_i),
    .flush   (flush_i),
    .ready   (ready),
    .wr_go   (wr_go),
    .rd_go   (rd_go),
    .ovf_evt (ovf_evt),
    .udf_evt (udf_evt),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .cnt_q   (cnt_q),
    .cnt_d   (cnt_d)
  );

  rxf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .wr_data (DATA_W'(wr_data_i)),
    .rd_go   (rd_go),
    .rd_addr (rd_addr),
    .rd_data (rd_word)
  );

  rxf_flags #(.ADDR_W(ADDR_W), .AE_INIT(AE_INIT), .AF_INIT(AF_INIT)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .cnt_d     (cnt_d),
    .thr_we    (thr_we_i),
    .thr_wdata (thr_wdata_i[THR_W-1:0]),
    .clr_we    (stat_clr_i),
    .clr_bits  ({stat_clr_data_i[ST_OVER], stat_clr_data_i[ST_UNDER]}),
    .ovf_evt   (ovf_evt),
    .udf_evt   (udf_evt),
    .thr_q     (thr_q),
    .status_q  (status_q)
  );

  assign rd_data_o = 32'(rd_word);
  assign thr_o     = REG_W'(thr_q);
  assign status_o  = status_q;
  assign count_o   = REG_W'(cnt_q);
  assign size_o    = REG_W'(DEPTH);
  assign ready_o   = ready;
endmodule

// File: rtl/rx_word_fifo_chk.sv
module rx_word_fifo_chk #(
  parameter int DEPTH = 32
) (
  input logic        clk,
  input logic        rst,
  input logic        rx_enable_i,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic        flush_i,
  input logic        stat_clr_i,
  input logic [31:0] stat_clr_data_i,
  input logic [31:0] rd_data_o,
  input logic [31:0] status_o,
  input logic [31:0] count_o,
  input logic        ready_o
);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count_o <= 32'(DEPTH));

  assert_nempty_R3: assert property (@(posedge clk) disable iff (rst)
    status_o[12] == (count_o != 32'd0));

  assert_ovr_set_R7: assert property (@(posedge clk) disable iff (rst)
    (ready_o && wr_en_i && rx_enable_i && !flush_i && count_o == 32'(DEPTH))
      |=> status_o[23]);

  assert_udr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ready_o && rd_en_i && !flush_i && count_o == 32'd0)
      |=> (status_o[22] && $stable(rd_data_o)));

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (status_o[23] && !(stat_clr_i && stat_clr_data_i[23])) |=> status_o[23]);

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (count_o == 32'd0));

  assert_settle_closed_R11: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> (count_o == 32'd0));

  assert_reset_clear_R12: assert property (@(posedge clk)
    rst |=> (count_o == 32'd0 && status_o[23:22] == 2'b00));
endmodule

bind rx_word_fifo rx_word_fifo_chk #(.DEPTH(1 << ADDR_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .rx_enable_i     (rx_enable_i),
  .wr_en_i         (wr_en_i),
  .rd_en_i         (rd_en_i),
  .flush_i         (flush_i),
  .stat_clr_i      (stat_clr_i),
  .stat_clr_data_i (stat_clr_data_i),
  .rd_data_o       (rd_data_o),
  .status_o        (status_o),
  .count_o         (count_o),
  .ready_o         (ready_o)
);

// File: tb/rx_word_fifo_test.sv
module rx_word_fifo_test;
  localparam int ADDR_W = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b1, wr_en = 1'b0, rd_en = 1'b0, flush = 1'b0;
  logic thr_we = 1'b0, clr_we = 1'b0;
  logic [31:0] wr_data = '0, thr_data = '0, clr_data = '0;
  logic [31:0] rd_data_o, thr_o, status_o, count_o, size_o;
  logic ready_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_word_fifo #(.DATA_W(32), .ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE),
                 .AE_INIT(4), .AF_INIT(4)) uut (
    .clk(clk), .rst(rst), .rx_enable_i(rx_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data_o),
    .flush_i(flush), .thr_we_i(thr_we), .thr_wdata_i(thr_data),
    .thr_o(thr_o), .stat_clr_i(clr_we), .stat_clr_data_i(clr_data),
    .status_o(status_o), .count_o(count_o), .size_o(size_o),
    .ready_o(ready_o));

  // ---------------- behavioural reference model ----------------
  logic [31:0] mq[$];
  bit m_ovr, m_udr, m_ready, m_valid;
  logic [23:0] m_thr;
  logic [31:0] m_rd;
  int m_settle;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_ovr = 0; m_udr = 0; m_thr = 24'h040004; m_rd = '0;
      m_settle = SETTLE; m_ready = (SETTLE == 0); m_valid = 1;
    end else begin
      bit acc, s_o, s_u;
      int sz;
      acc = m_ready; sz = mq.size(); s_o = 0; s_u = 0;
      if (flush) mq.delete();
      else begin
        if (acc && rd_en) begin
          if (sz == 0) s_u = 1; else m_rd = mq.pop_front();
        end
        if (acc && wr_en && rx_en) begin
          if (sz == DEPTH) s_o = 1; else mq.push_back(wr_data);
        end
      end
      if (clr_we && clr_data[23]) m_ovr = 0;
      if (clr_we && clr_data[22]) m_udr = 0;
      m_ovr = m_ovr | s_o;
      m_udr = m_udr | s_u;
      if (thr_we) m_thr = thr_data[23:0];
      if (m_settle != 0) begin m_settle--; m_ready = (m_settle == 0); end
      else m_ready = 1;
    end
  end

  function automatic logic [31:0] m_status();
    logic [31:0] s;
    int sz;
    sz = mq.size();
    s = '0;
    s[12] = (sz != 0);
    s[13] = (sz > int'(m_thr[15:0]));
    s[14] = ((sz + int'(m_thr[23:16])) < DEPTH);
    s[15] = (sz != DEPTH);
    s[22] = m_udr;
    s[23] = m_ovr;
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk(count_o == 32'(mq.size()), "R2 count vs model", count_o, 32'(mq.size()));
      chk(rd_data_o == m_rd, "R1 read data vs model", rd_data_o, m_rd);
      chk(ready_o == m_ready, "R11 ready vs model", 32'(ready_o), 32'(m_ready));
      chk(thr_o == {8'h0, m_thr}, "R4 threshold vs model", thr_o, {8'h0, m_thr});
      chk(status_o == m_status(), "status R3 R5 R6 R7 R8 R9 vs model", status_o, m_status());
    end
  end

  task automatic step(input logic w = 0, input logic [31:0] wd = 0, input logic r = 0,
                      input logic f = 0, input logic tw = 0, input logic [31:0] td = 0,
                      input logic cw = 0, input logic [31:0] cd = 0);
    wr_en = w; wr_data = wd; rd_en = r; flush = f;
    thr_we = tw; thr_data = td; clr_we = cw; clr_data = cd;
    @(negedge clk);
    wr_en = 0; rd_en = 0; flush = 0; thr_we = 0; clr_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog R1 actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    rst = 0;
    // R12 / R4 / R11 / R2 reset state
    chk(count_o == 0, "R12 count after reset", count_o, 0);
    chk(status_o == 32'h0000C000, "R12 status after reset", status_o, 32'h0000C000);
    chk(rd_data_o == 0, "R12 read data after reset", rd_data_o, 0);
    chk(thr_o == 32'h00040004, "R4 threshold default", thr_o, 32'h00040004);
    chk(ready_o == 1'b0, "R11 not ready after reset", 32'(ready_o), 0);
    chk(size_o == 32'(DEPTH), "R2 size", size_o, 32'(DEPTH));

    // R11 writes during settle are ignored
    repeat (3) step(.w(1), .wd(32'hDEAD0001));
    chk(count_o == 0, "R11 write ignored while settling", count_o, 0);
    for (int i = 0; i < 40 && !ready_o; i++) step();
    chk(ready_o == 1'b1, "R11 ready after settle", 32'(ready_o), 1);

    // R1 ordering
    for (int i = 0; i < 5; i++) step(.w(1), .wd(32'hA0000000 + i));
    chk(count_o == 5, "R2 count five", count_o, 5);
    for (int i = 0; i < 5; i++) begin
      step(.r(1));
      chk(rd_data_o == 32'hA0000000 + i, "R1 order", rd_data_o, 32'hA0000000 + i);
    end

    // R1 receive enable gates writes
    rx_en = 0;
    step(.w(1), .wd(32'h12345678));
    chk(count_o == 0, "R1 write ignored when disabled", count_o, 0);
    rx_en = 1;

    // R13 simultaneous read and write
    for (int i = 0; i < 3; i++) step(.w(1), .wd(32'hB0 + i));
    step(.w(1), .wd(32'hB3), .r(1));
    chk(count_o == 3, "R13 count unchanged", count_o, 3);
    chk(rd_data_o == 32'hB0, "R13 read data", rd_data_o, 32'hB0);
    for (int i = 1; i < 4; i++) begin
      step(.r(1));
      chk(rd_data_o == 32'hB0 + i, "R13 remaining order", rd_data_o, 32'hB0 + i);
    end

    // R3 / R7 fill, overrun
    for (int i = 0; i < DEPTH; i++) step(.w(1), .wd(32'hC0000000 + i));
    chk(status_o[15] == 1'b0, "R3 not-full low when full", status_o, 32'h0);
    step(.w(1), .wd(32'hEEEEEEEE));
    chk(status_o[23] == 1'b1, "R7 overrun set", status_o, 32'h00800000);
    chk(count_o == 32'(DEPTH), "R7 count held", count_o, 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      step(.r(1));
      chk(rd_data_o == 32'hC0000000 + i, "R7 contents intact", rd_data_o, 32'hC0000000 + i);
    end

    // R8 underrun
    step(.r(1));
    chk(rd_data_o == 32'hC000001F, "R8 data held", rd_data_o, 32'hC000001F);
    chk(status_o[22] == 1'b1, "R8 underrun set", status_o, 32'h00400000);

    // R9 write-one-to-clear
    step(.cw(1), .cd(32'h0));
    chk(status_o[23:22] == 2'b11, "R9 zero write keeps", status_o, 32'h00C00000);
    step(.cw(1), .cd(32'h00400000));
    chk(status_o[23:22] == 2'b10, "R9 clear underrun only", status_o, 32'h00800000);
    step(.r(1), .cw(1), .cd(32'h00400000));
    chk(status_o[22] == 1'b1, "R9 set wins over clear", status_o, 32'h00400000);
    step(.cw(1), .cd(32'h00C00000));
    chk(status_o[23:22] == 2'b00, "R9 clear both", status_o, 32'h0);

    // R4 / R5 / R6 thresholds
    step(.tw(1), .td(32'hFF06000A));
    chk(thr_o == 32'h0006000A, "R4 upper bits dropped", thr_o, 32'h0006000A);
    for (int i = 0; i < 10; i++) step(.w(1), .wd(i));
    chk(status_o[13] == 1'b0, "R5 at AE level", status_o, 32'h0);
    step(.w(1), .wd(10));
    chk(status_o[13] == 1'b1, "R5 above AE level", status_o, 32'h00002000);
    for (int i = 11; i < 25; i++) step(.w(1), .wd(i));
    chk(status_o[14] == 1'b1, "R6 below AF level", status_o, 32'h00004000);
    step(.w(1), .wd(25));
    chk(status_o[14] == 1'b0, "R6 at AF level", status_o, 32'h0);

    // R10 flush overrides and keeps flags
    for (int i = 26; i < DEPTH + 1; i++) step(.w(1), .wd(i));
    chk(status_o[23] == 1'b1, "R7 overrun before flush", status_o, 32'h00800000);
    step(.f(1), .w(1), .wd(32'h55), .r(1));
    chk(count_o == 0, "R10 flush empties", count_o, 0);
    chk(status_o[23] == 1'b1, "R10 flags kept", status_o, 32'h00800000);
    chk(rd_data_o == 32'hC000001F, "R10 read data kept", rd_data_o, 32'hC000001F);
    step(.tw(1), .td(32'h00FF0000));
    chk(status_o[14] == 1'b0, "R6 large AF", status_o, 32'h0);
    step(.tw(1), .td(32'h00040004), .cw(1), .cd(32'h00C00000));

    // random mix, checked each clock against the model
    for (int i = 0; i < 4000; i++) begin
      logic w, r, f, tw, cw;
      logic [31:0] td, cd;
      rx_en = ($urandom_range(9) != 0);
      w  = ($urandom_range(9) < 6);
      r  = ($urandom_range(9) < 5);
      f  = ($urandom_range(63) == 0);
      tw = ($urandom_range(99) == 0);
      td = {$urandom_range(255), 8'($urandom_range(40)), 16'($urandom_range(40))};
      cw = ($urandom_range(15) == 0);
      cd = $urandom;
      step(.w(w), .wd($urandom), .r(r), .f(f), .tw(tw), .td(td), .cw(cw), .cd(cd));
    end
    rx_en = 1;

    // R12 reset in mid run
    for (int i = 0; i < 4; i++) step(.w(1), .wd(i));
    rst = 1;
    step(.tw(1), .td(32'h00010001));
    rst = 0;
    chk(count_o == 0, "R12 mid-run reset count", count_o, 0);
    chk(thr_o == 32'h00040004, "R12 threshold default", thr_o, 32'h00040004);
    chk(status_o == 32'h0000C000, "R12 status", status_o, 32'h0000C000);
    chk(ready_o == 1'b0, "R11 closed after reset", 32'(ready_o), 0);

    step();
    finish_run();
  end
endmodule